// File: doc/BRIEF.md
# Slot Fault Latch and Interrupt Controller

This block collects fault events for a two-slot power controller and holds them as sticky bits in a status byte and a common-status byte. Software reads these bits to learn what went wrong. A fault is recorded only after power-on-reset has finished and while at least one slot-enable control bit is set. Several things can raise a fault: an undervoltage flag on any supply rail, a fast overcurrent trip, a slow overcurrent trip whose filter timeout has expired, a slow overcurrent trip while the slot is hot, or an overheated die.

Software clears a recorded fault by writing a 1 to its bit position, so the data stays put until the handler is ready for it. Bit 3 of the common-status byte is a mask. It selects between interrupt operation, in which an open-drain active-low request line is driven low while any fault bit is held, and polled operation, in which the line is never driven. All outputs are registered. Fault bits, readback bytes and the line enable all change on the same clock edge.

Top module: `fault_irq_ctrl`

## Requirements
- R1: No fault bit sets in any clock cycle in which `por_done` is 0, whatever the fault inputs are.
- R2: No fault bit sets in a cycle in which both `slot_en` bits are 0.
- R3: With qualification met, `stat_q` bit 0 (slot 0) or bit 2 (slot 1) sets on the next edge when that slot's `oc_fast` is 1, or when both its `oc_slow` and `oc_filt_done` are 1.
- R4: A slow trip alone (`oc_slow` 1 while `oc_filt_done` and `slot_hot` are both 0) sets no bit.
- R5: With qualification met, any bit of `uv_flag` sets `stat_q` bit 4.
- R6: With qualification met, `oc_slow` and `slot_hot` both 1 on the same slot set `cs_q` bit 1.
- R7: With qualification met, `die_hot` sets `cs_q` bit 2.
- R8: A status write with a 1 in a fault bit position clears that bit on the next edge. A 0 in that position leaves the bit unchanged. The same holds for common-status writes to bits 1 and 2.
- R9: If a set condition and a clear write hit the same bit in the same cycle, the bit stays set. So a fault that persists sets its bit again right after a clear.
- R10: `cs_q` bit 3 is the mask. It resets to 1 and takes bit 3 of every common-status write. While it is 1, `int_oe` stays 0.
- R11: While the mask is 0, `int_oe` is 1 exactly when any of `stat_q` bits 4, 2, 0 or `cs_q` bits 2, 1 is 1.
- R12: After reset, all fault bits are 0, `cs_q` reads 8'h08 and `int_oe` is 0. Status bits 7, 6, 5, 3, 1 and common-status bits 7 to 4 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_done | input | 1 | Power-on-reset delay has elapsed |
| slot_en | input | 2 | Slot-enable control bits, one per slot |
| uv_flag | input | NUM_RAILS | Undervoltage flags, one per supply rail |
| oc_fast | input | 2 | Fast overcurrent trip per slot |
| oc_slow | input | 2 | Slow overcurrent trip per slot |
| oc_filt_done | input | 2 | Slow-trip filter timeout expired per slot |
| slot_hot | input | 2 | Slot temperature above 140 °C |
| die_hot | input | 1 | Global die temperature above 160 °C |
| stat_wr_en | input | 1 | Write strobe for the status byte |
| stat_wr_data | input | 8 | Status write data (write one to clear) |
| cs_wr_en | input | 1 | Write strobe for the common-status byte |
| cs_wr_data | input | 8 | Common-status write data (bit 3 mask, bits 2:1 clear) |
| stat_q | output | 8 | Status byte readback |
| cs_q | output | 8 | Common-status byte readback |
| int_oe | output | 1 | Drive-low enable of the open-drain interrupt line |

## Verification
The main qualification function is swept over every combination of the slot-enable, undervoltage, overcurrent, filter, slot-temperature and die-temperature inputs. Each combination is applied for one cycle and then cleared. This separates the fast-trip path from the filtered slow path, isolates the thermal slow path from both, and shows that a slow trip alone and a disabled pair of slots record nothing. Directed sequences then hold faults while the reset delay has not finished, write zeros and partial one-masks to show that bits are retained, collide a live fault with its own clear, and toggle the mask while bits are held. These tell polled operation apart from interrupt operation.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_SLOTS  = 2;
  // Fault vector layout inside the block
  localparam int FV_SLOT0   = 0;
  localparam int FV_SLOT1   = 1;
  localparam int FV_UV      = 2;
  localparam int FV_THERM   = 3;
  localparam int FV_DIE     = 4;
  localparam int FV_W       = 5;
  // Register bit positions decoded by software
  localparam int ST_SLOT0   = 0;
  localparam int ST_SLOT1   = 2;
  localparam int ST_UV      = 4;
  localparam int CS_THERM   = 1;
  localparam int CS_DIE     = 2;
  localparam int CS_MASK    = 3;
endpackage

// File: rtl/fault_qual.sv
module fault_qual
  import fault_pkg::*;
#(
  parameter int NUM_RAILS = 3
) (
  input  logic                 por_done,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic [NUM_RAILS-1:0] uv_flag,
  input  logic [NUM_SLOTS-1:0] oc_fast,
  input  logic [NUM_SLOTS-1:0] oc_slow,
  input  logic [NUM_SLOTS-1:0] oc_filt_done,
  input  logic [NUM_SLOTS-1:0] slot_hot,
  input  logic                 die_hot,
  output logic [FV_W-1:0]      set_vec
);
  logic                 armed;
  logic [NUM_SLOTS-1:0] slot_trip;
  logic [NUM_SLOTS-1:0] therm_trip;

  assign armed = por_done & (|slot_en);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_trip[s]  = oc_fast[s] | (oc_slow[s] & oc_filt_done[s]);
    assign therm_trip[s] = oc_slow[s] & slot_hot[s];
  end

  always_comb begin
    set_vec           = '0;
    set_vec[FV_SLOT0] = armed & slot_trip[0];
    set_vec[FV_SLOT1] = armed & slot_trip[1];
    set_vec[FV_UV]    = armed & (|uv_flag);
    set_vec[FV_THERM] = armed & (|therm_trip);
    set_vec[FV_DIE]   = armed & die_hot;
  end
endmodule

// File: rtl/w1c_latch.sv
module w1c_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    // set wins over a clear in the same cycle
    assign d_o[b] = set_i[b] | (q_o[b] & ~clr_i[b]);
    always_ff @(posedge clk) begin
      if (rst) q_o[b] <= 1'b0;
      else     q_o[b] <= d_o[b];
    end
  end
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_d,
  input  logic [W-1:0] fault_d,
  output logic         int_oe
);
  always_ff @(posedge clk) begin
    if (rst) int_oe <= 1'b0;
    else     int_oe <= ~mask_d & (|fault_d);
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_pkg::*;
#(
  parameter int NUM_RAILS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por_done,
  input  logic [1:0]           slot_en,
  input  logic [NUM_RAILS-1:0] uv_flag,
  input  logic [1:0]           oc_fast,
  input  logic [1:0]           oc_slow,
  input  logic [1:0]           oc_filt_done,
  input  logic [1:0]           slot_hot,
  input  logic                 die_hot,
  input  logic                 stat_wr_en,
  input  logic [7:0]           stat_wr_data,
  input  logic                 cs_wr_en,
  input  logic [7:0]           cs_wr_data,
  output logic [7:0]           stat_q,
  output logic [7:0]           cs_q,
  output logic                 int_oe
);
  logic [FV_W-1:0] set_vec, clr_vec, fault_d, fault_q;
  logic            mask_d, mask_q;
  logic            unused_wr_bits;

  assign unused_wr_bits = ^{stat_wr_data[7:5], stat_wr_data[3], stat_wr_data[1],
                            cs_wr_data[7:4], cs_wr_data[0]};

  fault_qual #(.NUM_RAILS(NUM_RAILS)) u_qual (
    .por_done     (por_done),
    .slot_en      (slot_en),
    .uv_flag      (uv_flag),
    .oc_fast      (oc_fast),
    .oc_slow      (oc_slow),
    .oc_filt_done (oc_filt_done),
    .slot_hot     (slot_hot),
    .die_hot      (die_hot),
    .set_vec      (set_vec)
  );

  always_comb begin
    clr_vec           = '0;
    clr_vec[FV_SLOT0] = stat_wr_en & stat_wr_data[ST_SLOT0];
    clr_vec[FV_SLOT1] = stat_wr_en & stat_wr_data[ST_SLOT1];
    clr_vec[FV_UV]    = stat_wr_en & stat_wr_data[ST_UV];
    clr_vec[FV_THERM] = cs_wr_en   & cs_wr_data[CS_THERM];
    clr_vec[FV_DIE]   = cs_wr_en   & cs_wr_data[CS_DIE];
  end

  w1c_latch #(.W(FV_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .d_o   (fault_d),
    .q_o   (fault_q)
  );

  assign mask_d = cs_wr_en ? cs_wr_data[CS_MASK] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= 1'b1;
    else     mask_q <= mask_d;
  end

  irq_drive #(.W(FV_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .mask_d  (mask_d),
    .fault_d (fault_d),
    .int_oe  (int_oe)
  );

  always_comb begin
    stat_q           = '0;
    stat_q[ST_SLOT0] = fault_q[FV_SLOT0];
    stat_q[ST_SLOT1] = fault_q[FV_SLOT1];
    stat_q[ST_UV]    = fault_q[FV_UV];
    cs_q             = '0;
    cs_q[CS_THERM]   = fault_q[FV_THERM];
    cs_q[CS_DIE]     = fault_q[FV_DIE];
    cs_q[CS_MASK]    = mask_q;
  end
endmodule

// File: rtl/fault_irq_chk.sv
module fault_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_done,
  input logic [1:0] slot_en,
  input logic [1:0] oc_fast,
  input logic       stat_wr_en,
  input logic [7:0] stat_wr_data,
  input logic       cs_wr_en,
  input logic [7:0] cs_wr_data,
  input logic [7:0] stat_q,
  input logic [7:0] cs_q,
  input logic       int_oe
);
  logic [4:0] held;
  assign held = {stat_q[4], stat_q[2], stat_q[0], cs_q[2], cs_q[1]};

  // R1
  por_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!por_done && held == 5'b0) |=> held == 5'b0);

  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_en == 2'b00 && held == 5'b0) |=> held == 5'b0);

  // R8
  hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !(stat_wr_en && stat_wr_data[0])) |=> stat_q[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (por_done && slot_en != 2'b00 && oc_fast[0]) |=> stat_q[0]);

  // R10
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_q[3] |-> !int_oe);

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    cs_wr_en |=> cs_q[3] == $past(cs_wr_data[3]));

  // R11
  int_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_q[3] |-> int_oe == (held != 5'b0));

  // R12
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & 8'hEA) == 8'h00 && (cs_q & 8'hF1) == 8'h00);
endmodule

bind fault_irq_ctrl fault_irq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .por_done     (por_done),
  .slot_en      (slot_en),
  .oc_fast      (oc_fast),
  .stat_wr_en   (stat_wr_en),
  .stat_wr_data (stat_wr_data),
  .cs_wr_en     (cs_wr_en),
  .cs_wr_data   (cs_wr_data),
  .stat_q       (stat_q),
  .cs_q         (cs_q),
  .int_oe       (int_oe)
);

// File: tb/tb_fault_irq_ctrl.sv
module tb_fault_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_done = 1'b0;
  logic [1:0] slot_en = '0;
  logic [2:0] uv_flag = '0;
  logic [1:0] oc_fast = '0, oc_slow = '0, oc_filt_done = '0, slot_hot = '0;
  logic       die_hot = 1'b0;
  logic       stat_wr_en = 1'b0, cs_wr_en = 1'b0;
  logic [7:0] stat_wr_data = '0, cs_wr_data = '0;
  logic [7:0] stat_q, cs_q;
  logic       int_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_irq_ctrl #(.NUM_RAILS(3)) dut (
    .clk(clk), .rst(rst), .por_done(por_done), .slot_en(slot_en),
    .uv_flag(uv_flag), .oc_fast(oc_fast), .oc_slow(oc_slow),
    .oc_filt_done(oc_filt_done), .slot_hot(slot_hot), .die_hot(die_hot),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .cs_wr_en(cs_wr_en), .cs_wr_data(cs_wr_data),
    .stat_q(stat_q), .cs_q(cs_q), .int_oe(int_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    slot_en = '0; uv_flag = '0; oc_fast = '0; oc_slow = '0;
    oc_filt_done = '0; slot_hot = '0; die_hot = 1'b0;
    stat_wr_en = 1'b0; cs_wr_en = 1'b0; stat_wr_data = '0; cs_wr_data = '0;
  endtask

  task automatic check(string req, logic [7:0] es, logic [7:0] ec, logic ei);
    checks++;
    if (stat_q !== es || cs_q !== ec || int_oe !== ei) begin
      errors++;
      $display("FAIL %s: stat=%h cs=%h int=%b expected stat=%h cs=%h int=%b",
               req, stat_q, cs_q, int_oe, es, ec, ei);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    step(); step();
    rst = 1'b0;
    step();
    // R12: reset state, mask set
    check("R12 reset", 8'h00, 8'h08, 1'b0);

    // R1: faults present, por not done
    slot_en = 2'b11; uv_flag = 3'b111; oc_fast = 2'b11; oc_slow = 2'b11;
    oc_filt_done = 2'b11; slot_hot = 2'b11; die_hot = 1'b1;
    cs_wr_en = 1'b1; cs_wr_data = 8'h00;   // R10: unmask
    step();
    check("R1 por gate", 8'h00, 8'h00, 1'b0);
    cs_wr_en = 1'b0;
    step();
    check("R1 por gate held", 8'h00, 8'h00, 1'b0);
    idle_inputs();
    por_done = 1'b1;
    step();

    // R2 R3 R4 R5 R6 R7 R11 R8: full sweep of fault inputs
    for (int v = 0; v < (1 << 14); v++) begin
      logic [13:0] p;
      logic        armed, s0, s2, s4, c1, c2;
      logic [7:0]  es, ec;
      p = v[13:0];
      slot_en = p[1:0]; uv_flag = p[4:2]; oc_fast = p[6:5]; oc_slow = p[8:7];
      oc_filt_done = p[10:9]; slot_hot = p[12:11]; die_hot = p[13];
      armed = (p[1:0] != 2'b00);
      s0 = armed & (p[5] | (p[7] & p[9]));
      s2 = armed & (p[6] | (p[8] & p[10]));
      s4 = armed & (p[4:2] != 3'b000);
      c1 = armed & ((p[7] & p[11]) | (p[8] & p[12]));
      c2 = armed & p[13];
      es = 8'h00; es[0] = s0; es[2] = s2; es[4] = s4;
      ec = 8'h00; ec[1] = c1; ec[2] = c2;
      step();
      check("R2/R3/R4/R5/R6/R7/R11 sweep", es, ec, (es != 0) || (ec != 0));
      idle_inputs();
      stat_wr_en = 1'b1; stat_wr_data = 8'hFF;
      cs_wr_en = 1'b1; cs_wr_data = 8'h06;
      step();
      check("R8 clear after sweep point", 8'h00, 8'h00, 1'b0);
      idle_inputs();
    end

    // R2 directed: all faults, no slot enabled
    uv_flag = 3'b111; oc_fast = 2'b11; die_hot = 1'b1;
    step();
    check("R2 no enable", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    // R4 directed: slow trip alone on both slots
    slot_en = 2'b01; oc_slow = 2'b11;
    step();
    check("R4 slow alone", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    // R8: write zeros and other-bit ones keep bit 0
    slot_en = 2'b10; oc_fast = 2'b01;
    step();
    check("R3 slot0 fast", 8'h01, 8'h00, 1'b1);
    idle_inputs();
    stat_wr_en = 1'b1; stat_wr_data = 8'h00;
    step();
    check("R8 write zero keeps", 8'h01, 8'h00, 1'b1);
    stat_wr_data = 8'hFE;
    cs_wr_en = 1'b1; cs_wr_data = 8'h06;
    step();
    check("R8 other ones keep", 8'h01, 8'h00, 1'b1);
    idle_inputs();
    stat_wr_en = 1'b1; stat_wr_data = 8'h01;
    step();
    check("R8 write one clears", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    // R9: live fault collides with its clear
    slot_en = 2'b01; oc_fast = 2'b01;
    step();
    stat_wr_en = 1'b1; stat_wr_data = 8'h01;
    step();
    check("R9 set beats clear", 8'h01, 8'h00, 1'b1);
    oc_fast = 2'b00;
    step();
    check("R9 clear once fault gone", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    // R10: masked, bits latch but line stays released
    cs_wr_en = 1'b1; cs_wr_data = 8'h08;
    slot_en = 2'b01; die_hot = 1'b1;
    step();
    check("R10 masked latch", 8'h00, 8'h0C, 1'b0);
    idle_inputs();
    step();
    check("R10 masked hold", 8'h00, 8'h0C, 1'b0);
    // R11: unmask with bit held
    cs_wr_en = 1'b1; cs_wr_data = 8'h00;
    step();
    check("R11 unmask asserts", 8'h00, 8'h04, 1'b1);
    cs_wr_data = 8'h04;
    step();
    check("R11 clear releases", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    // R12: reserved bits stay zero under all-ones writes
    stat_wr_en = 1'b1; stat_wr_data = 8'hFF;
    cs_wr_en = 1'b1; cs_wr_data = 8'hF7;
    step();
    check("R12 reserved zero", 8'h00, 8'h00, 1'b0);
    idle_inputs();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule